// File: doc/BRIEF.md
# Pipelined Read Bus Protocol Monitor

This block is a synthesizable checker that sits beside a read master on a pipelined request/acknowledge bus and beside the valid/ready stream that carries fetched words downstream. It drives nothing on either interface. It keeps live statistics on the bus: how many requests are in flight, how long the current request has been held off by the slave, and how long the master has waited for an acknowledge. It also follows the address the next request should carry, and the last address handed downstream.

A redirect port (valid plus a new address) moves the expected address to a new starting point. It also forgets the last delivered address. When the master, the slave or the downstream consumer breaks a rule, a sticky flag is raised. Each flag stays set until reset, so a long run can be read out once at the end. Each flag has a fixed bit in the error vector.

Every flag and counter is registered. A violation in cycle t shows on the outputs after the clock edge that ends cycle t. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `rdbus_monitor`

## Requirements
- R1: `outstanding_o` rises by one after a cycle with CYC, STB high and STALL low, and falls by one after a cycle with CYC and ACK high while it is non-zero. When both happen in the same cycle it holds its value. It never goes below zero, saturates at its maximum, and is not changed by CYC dropping.
- R2: `stall_run_o` counts consecutive cycles with CYC, STB and STALL all high. `ack_wait_o` counts consecutive cycles with CYC high, ACK low and `outstanding_o` non-zero. `ds_stall_run_o` counts consecutive cycles with stream valid high and ready low. Each counter returns to 0 after a cycle in which its condition is false, and saturates at its maximum.
- R3: `exp_addr_o` is loaded from `redir_addr_i` after a cycle with `redir_valid_i` high. Otherwise it increments after a cycle with CYC and ACK high. A redirect wins over a simultaneous ACK.
- R4: Error bit 0 is set after a cycle with STB high and CYC low. Error bit 1 is set after a cycle with ACK high while `outstanding_o` is 0.
- R5: Error bit 2 is set after a cycle with ACK high when CYC was low in the previous cycle; the first cycle after reset counts as following a CYC-low cycle.
- R6: Error bit 3 is set after a cycle with CYC and STB high whose bus address differs from `exp_addr_o`.
- R7: Error bits 4, 5 and 6 are set when `stall_run_o`, `ack_wait_o` and `ds_stall_run_o` respectively exceed LAT_MAX, i.e. on the edge at which the counter reaches LAT_MAX+1. A counter value of LAT_MAX sets nothing.
- R8: A stream transfer (valid and ready) stores its address in `last_addr_o` and sets `last_valid_o`. A redirect clears `last_valid_o`, taking priority over a simultaneous transfer. Error bit 7 is set after a transfer whose address is not `last_addr_o`+1 while `last_valid_o` is set.
- R9: Error bit 8 is set when a cycle with CYC, STB and STALL high is followed by a cycle with STB low or a different bus address. Error bit 9 is set when a cycle with stream valid high and ready low is followed by a cycle with valid low, or a different address or data. Neither check applies if `redir_valid_i` is high in either of the two cycles.
- R10: Error bits stay set until reset. While `rst_ni` is low all counters, flags, `exp_addr_o` and `last_valid_o` read 0. After `rst_ni` rises, the block resumes on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cyc_i | input | 1 | Bus cycle active |
| bus_stb_i | input | 1 | Request strobe |
| bus_stall_i | input | 1 | Slave holds off the request |
| bus_adr_i | input | AW | Request address |
| bus_ack_i | input | 1 | Slave acknowledge |
| st_valid_i | input | 1 | Downstream word valid |
| st_ready_i | input | 1 | Downstream consumer ready |
| st_addr_i | input | AW | Downstream word address |
| st_data_i | input | DW | Downstream word data |
| redir_valid_i | input | 1 | Redirect request |
| redir_addr_i | input | AW | Redirect start address |
| outstanding_o | output | OUT_W | Requests in flight |
| stall_run_o | output | CNT_W | Current slave stall run length |
| ack_wait_o | output | CNT_W | Current acknowledge wait |
| ds_stall_run_o | output | CNT_W | Current downstream stall run length |
| exp_addr_o | output | AW | Expected next request address |
| last_addr_o | output | AW | Last address delivered downstream |
| last_valid_o | output | 1 | `last_addr_o` is meaningful |
| err_o | output | 10 | Sticky violation flags, bit positions per R4 to R9 |

## Verification
The bench builds the block with AW=8, DW=8, OUT_W=2, CNT_W=3 and LAT_MAX=2. With this bound, a three-cycle stall or wait puts both the last quiet cycle (count 2) and the first flagged cycle (count 3) inside a few vectors. The 8-bit addresses keep the vector table narrow while still covering redirect reloads and the same-cycle issue-plus-acknowledge case. Each violation is provoked alone after a fresh reset, so the exact flag bit and the cycle it appears in can be compared. The redirect exemptions are shown by repeating a violation with redirect raised.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  // Number of sticky violation flags and their positions in err_o.
  localparam int ERR_N          = 10;
  localparam int ERR_STB_NOCYC  = 0;
  localparam int ERR_ACK_NONE   = 1;
  localparam int ERR_ACK_IDLE   = 2;
  localparam int ERR_ADR        = 3;
  localparam int ERR_STALL_LONG = 4;
  localparam int ERR_ACK_LATE   = 5;
  localparam int ERR_DS_LONG    = 6;
  localparam int ERR_DS_SEQ     = 7;
  localparam int ERR_BUS_HOLD   = 8;
  localparam int ERR_DS_HOLD    = 9;

  // Number of run-length counters kept by the monitor.
  localparam int RUN_N     = 3;
  localparam int RUN_STALL = 0;
  localparam int RUN_WAIT  = 1;
  localparam int RUN_DS    = 2;

  typedef struct packed {
    logic cyc;
    logic stb;
    logic stall;
    logic ack;
  } bus_ctl_t;

endpackage

// File: rtl/rbm_rst_sync.sv
module rbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/rbm_run_cnt.sv
module rbm_run_cnt #(
  parameter int CNT_W = 4,
  parameter int LIM   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cond_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIM);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             over;

  always_comb begin
    // Next count exceeds LIM exactly when the present count has reached it.
    over = cond_i && (cnt_q >= CNT_LIM);
    if (!cond_i) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    err_d = err_q | over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  // R2: a run ends as soon as its condition drops
  a_r2_run_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> (cnt_q == '0));

  // R7: one more qualifying cycle at the bound raises the flag
  a_r7_bound_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && cnt_q == CNT_LIM) |=> err_q);

  // R7: below the bound, a fresh run leaves a clear flag clear
  a_r7_below_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && cnt_q < CNT_LIM) |=> !err_q);

endmodule

// File: rtl/rbm_bus_track.sv
module rbm_bus_track
  import rbm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_ctl_t         ctl_i,
  input  logic [AW-1:0]    adr_i,
  input  logic             redir_valid_i,
  input  logic [AW-1:0]    redir_addr_i,
  output logic [OUT_W-1:0] out_o,
  output logic [AW-1:0]    exp_o,
  output logic             stall_cond_o,
  output logic             wait_cond_o,
  output logic [4:0]       err_o
);

  // Local flag positions inside err_o
  localparam int L_NOCYC = 0;
  localparam int L_NONE  = 1;
  localparam int L_IDLE  = 2;
  localparam int L_ADR   = 3;
  localparam int L_HOLD  = 4;

  localparam logic [OUT_W-1:0] OUT_MAX = '1;

  logic [OUT_W-1:0] out_q, out_d;
  logic [AW-1:0]    exp_q, exp_d;
  logic             idle_q, idle_d;
  logic             hold_q, hold_d;
  logic [AW-1:0]    hadr_q;
  logic [4:0]       err_q, err_d;
  logic [4:0]       viol;

  logic issue, take, inc, dec, arm, hadr_en;

  always_comb begin
    issue = ctl_i.cyc & ctl_i.stb & ~ctl_i.stall;
    take  = ctl_i.cyc & ctl_i.ack;
    dec   = take && (out_q != '0);
    inc   = issue && ((out_q != OUT_MAX) || dec);

    out_d = out_q;
    if (inc && !dec) begin
      out_d = out_q + OUT_W'(1);
    end else if (dec && !inc) begin
      out_d = out_q - OUT_W'(1);
    end

    if (redir_valid_i) begin
      exp_d = redir_addr_i;
    end else if (take) begin
      exp_d = exp_q + AW'(1);
    end else begin
      exp_d = exp_q;
    end

    idle_d  = ~ctl_i.cyc;
    arm     = ctl_i.cyc & ctl_i.stb & ctl_i.stall & ~redir_valid_i;
    hold_d  = arm;
    hadr_en = arm;

    viol         = '0;
    viol[L_NOCYC] = ctl_i.stb & ~ctl_i.cyc;
    viol[L_NONE]  = ctl_i.ack & (out_q == '0);
    viol[L_IDLE]  = ctl_i.ack & idle_q;
    viol[L_ADR]   = ctl_i.cyc & ctl_i.stb & (adr_i != exp_q);
    viol[L_HOLD]  = hold_q & ~redir_valid_i & (~ctl_i.stb | (adr_i != hadr_q));

    err_d = err_q | viol;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      exp_q  <= '0;
      idle_q <= 1'b1;
      hold_q <= 1'b0;
      err_q  <= '0;
    end else begin
      out_q  <= out_d;
      exp_q  <= exp_d;
      idle_q <= idle_d;
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  // Captured address needs no reset: it is only read while hold_q is set.
  always_ff @(posedge clk_i) begin
    if (hadr_en) begin
      hadr_q <= adr_i;
    end
  end

  assign out_o        = out_q;
  assign exp_o        = exp_q;
  assign stall_cond_o = ctl_i.cyc & ctl_i.stb & ctl_i.stall;
  assign wait_cond_o  = ctl_i.cyc & ~ctl_i.ack & (out_q != '0);
  assign err_o        = err_q;

  // R1: an accepted request with no acknowledge adds one in flight
  a_r1_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.cyc && ctl_i.stb && !ctl_i.stall && !ctl_i.ack && out_q != OUT_MAX)
    |=> (out_q == $past(out_q) + OUT_W'(1)));

  // R1: with CYC low nothing changes the in-flight count
  a_r1_cyc_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.cyc |=> (out_q == $past(out_q)));

  // R3: a redirect reloads the expected address
  a_r3_redir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |=> (exp_q == $past(redir_addr_i)));

  // R4: strobe without cycle is flagged
  a_r4_stb_no_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.stb && !ctl_i.cyc) |=> err_q[L_NOCYC]);

  // R5: acknowledge right after an idle cycle is flagged
  a_r5_ack_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.cyc ##1 ctl_i.ack) |=> err_q[L_IDLE]);

  // R9: a stalled request that drops its strobe without redirect is flagged
  a_r9_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_i.cyc && ctl_i.stb && ctl_i.stall && !redir_valid_i)
     ##1 (!redir_valid_i && !ctl_i.stb)) |=> err_q[L_HOLD]);

endmodule

// File: rtl/rbm_stream_track.sv
module rbm_stream_track #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          ready_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          redir_valid_i,
  output logic [AW-1:0] last_o,
  output logic          last_vld_o,
  output logic          ds_cond_o,
  output logic [1:0]    err_o
);

  // Local flag positions inside err_o
  localparam int L_SEQ  = 0;
  localparam int L_HOLD = 1;

  logic [AW-1:0] last_q;
  logic          lv_q, lv_d;
  logic          hold_q, hold_d;
  logic [AW-1:0] ha_q;
  logic [DW-1:0] hd_q;
  logic [1:0]    err_q, err_d;
  logic [1:0]    viol;
  logic          xfer, arm, last_en;

  always_comb begin
    xfer    = valid_i & ready_i;
    last_en = xfer;

    if (redir_valid_i) begin
      lv_d = 1'b0;
    end else if (xfer) begin
      lv_d = 1'b1;
    end else begin
      lv_d = lv_q;
    end

    arm    = valid_i & ~ready_i & ~redir_valid_i;
    hold_d = arm;

    viol         = '0;
    viol[L_SEQ]  = xfer & lv_q & (addr_i != last_q + AW'(1));
    viol[L_HOLD] = hold_q & ~redir_valid_i &
                   (~valid_i | (addr_i != ha_q) | (data_i != hd_q));

    err_d = err_q | viol;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q   <= 1'b0;
      hold_q <= 1'b0;
      err_q  <= '0;
    end else begin
      lv_q   <= lv_d;
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= addr_i;
    end
  end

  // Held word needs no reset: it is only read while hold_q is set.
  always_ff @(posedge clk_i) begin
    if (arm) begin
      ha_q <= addr_i;
      hd_q <= data_i;
    end
  end

  assign last_o     = last_q;
  assign last_vld_o = lv_q;
  assign ds_cond_o  = valid_i & ~ready_i;
  assign err_o      = err_q;

  // R8: a transfer without redirect is remembered
  a_r8_last_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && !redir_valid_i) |=> (lv_q && last_q == $past(addr_i)));

  // R8: a redirect forgets the last delivered address
  a_r8_redir_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |=> !lv_q);

  // R9: a waiting word that vanishes without redirect is flagged
  a_r9_ds_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_i && !ready_i && !redir_valid_i) ##1 (!redir_valid_i && !valid_i))
    |=> err_q[L_HOLD]);

endmodule

// File: rtl/rdbus_monitor.sv
module rdbus_monitor
  import rbm_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int OUT_W   = 4,
  parameter int CNT_W   = 4,
  parameter int LAT_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_cyc_i,
  input  logic             bus_stb_i,
  input  logic             bus_stall_i,
  input  logic [AW-1:0]    bus_adr_i,
  input  logic             bus_ack_i,
  input  logic             st_valid_i,
  input  logic             st_ready_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic             redir_valid_i,
  input  logic [AW-1:0]    redir_addr_i,
  output logic [OUT_W-1:0] outstanding_o,
  output logic [CNT_W-1:0] stall_run_o,
  output logic [CNT_W-1:0] ack_wait_o,
  output logic [CNT_W-1:0] ds_stall_run_o,
  output logic [AW-1:0]    exp_addr_o,
  output logic [AW-1:0]    last_addr_o,
  output logic             last_valid_o,
  output logic [ERR_N-1:0] err_o
);

  logic             rst_n;
  bus_ctl_t         ctl;
  logic [4:0]       bus_err;
  logic [1:0]       ds_err;
  logic [RUN_N-1:0] run_cond;
  logic [RUN_N-1:0] run_err;
  logic [CNT_W-1:0] run_cnt [RUN_N];
  logic             stall_cond, wait_cond, ds_cond;

  rbm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    ctl.cyc   = bus_cyc_i;
    ctl.stb   = bus_stb_i;
    ctl.stall = bus_stall_i;
    ctl.ack   = bus_ack_i;
  end

  rbm_bus_track #(.AW(AW), .OUT_W(OUT_W)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .ctl_i         (ctl),
    .adr_i         (bus_adr_i),
    .redir_valid_i (redir_valid_i),
    .redir_addr_i  (redir_addr_i),
    .out_o         (outstanding_o),
    .exp_o         (exp_addr_o),
    .stall_cond_o  (stall_cond),
    .wait_cond_o   (wait_cond),
    .err_o         (bus_err)
  );

  rbm_stream_track #(.AW(AW), .DW(DW)) u_ds (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .valid_i       (st_valid_i),
    .ready_i       (st_ready_i),
    .addr_i        (st_addr_i),
    .data_i        (st_data_i),
    .redir_valid_i (redir_valid_i),
    .last_o        (last_addr_o),
    .last_vld_o    (last_valid_o),
    .ds_cond_o     (ds_cond),
    .err_o         (ds_err)
  );

  always_comb begin
    run_cond            = '0;
    run_cond[RUN_STALL] = stall_cond;
    run_cond[RUN_WAIT]  = wait_cond;
    run_cond[RUN_DS]    = ds_cond;
  end

  for (genvar g = 0; g < RUN_N; g++) begin : g_run
    rbm_run_cnt #(.CNT_W(CNT_W), .LIM(LAT_MAX)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .cond_i (run_cond[g]),
      .cnt_o  (run_cnt[g]),
      .err_o  (run_err[g])
    );
  end

  assign stall_run_o    = run_cnt[RUN_STALL];
  assign ack_wait_o     = run_cnt[RUN_WAIT];
  assign ds_stall_run_o = run_cnt[RUN_DS];

  always_comb begin
    err_o                 = '0;
    err_o[ERR_STB_NOCYC]  = bus_err[0];
    err_o[ERR_ACK_NONE]   = bus_err[1];
    err_o[ERR_ACK_IDLE]   = bus_err[2];
    err_o[ERR_ADR]        = bus_err[3];
    err_o[ERR_BUS_HOLD]   = bus_err[4];
    err_o[ERR_STALL_LONG] = run_err[RUN_STALL];
    err_o[ERR_ACK_LATE]   = run_err[RUN_WAIT];
    err_o[ERR_DS_LONG]    = run_err[RUN_DS];
    err_o[ERR_DS_SEQ]     = ds_err[0];
    err_o[ERR_DS_HOLD]    = ds_err[1];
  end

  // R10: once raised, no flag falls before reset
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    ##1 ((err_o & $past(err_o)) == $past(err_o)));

  // R6: a strobed request away from the expected address is flagged
  a_r6_addr_check: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_cyc_i && bus_stb_i && bus_adr_i != exp_addr_o) |=> err_o[ERR_ADR]);

endmodule

// File: tb/test_rdbus_monitor.sv
module test_rdbus_monitor;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int OUT_W = 2;
  localparam int CNT_W = 3;
  localparam int LAT_MAX = 2;
  localparam int NV = 12;

  // Vector: redir, raddr[8], cyc, stb, stall, ack, adr[8] | out[2], stall[3], wait[3], exp[8]
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 8'h10, 4'b0000, 8'h00, 2'd0, 3'd0, 3'd0, 8'h10},
    {1'b0, 8'h00, 4'b1100, 8'h10, 2'd1, 3'd0, 3'd0, 8'h10},
    {1'b0, 8'h00, 4'b1000, 8'h00, 2'd1, 3'd0, 3'd1, 8'h10},
    {1'b0, 8'h00, 4'b1001, 8'h00, 2'd0, 3'd0, 3'd0, 8'h11},
    {1'b0, 8'h00, 4'b1110, 8'h11, 2'd0, 3'd1, 3'd0, 8'h11},
    {1'b0, 8'h00, 4'b1110, 8'h11, 2'd0, 3'd2, 3'd0, 8'h11},
    {1'b0, 8'h00, 4'b1100, 8'h11, 2'd1, 3'd0, 3'd0, 8'h11},
    {1'b0, 8'h00, 4'b1000, 8'h00, 2'd1, 3'd0, 3'd1, 8'h11},
    {1'b0, 8'h00, 4'b1101, 8'h11, 2'd1, 3'd0, 3'd0, 8'h12},
    {1'b0, 8'h00, 4'b1001, 8'h00, 2'd0, 3'd0, 3'd0, 8'h13},
    {1'b0, 8'h00, 4'b0000, 8'h00, 2'd0, 3'd0, 3'd0, 8'h13},
    {1'b1, 8'h20, 4'b0000, 8'h00, 2'd0, 3'd0, 3'd0, 8'h20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc, stb, stall, ack, sv, sr, rv;
  logic [AW-1:0] adr, sa, ra;
  logic [DW-1:0] sd;
  logic [OUT_W-1:0] outstanding;
  logic [CNT_W-1:0] stall_run, ack_wait, ds_run;
  logic [AW-1:0] exp_addr, last_addr;
  logic last_valid;
  logic [9:0] err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rdbus_monitor #(.AW(AW), .DW(DW), .OUT_W(OUT_W), .CNT_W(CNT_W), .LAT_MAX(LAT_MAX))
  i_rdbus_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_stall_i(stall), .bus_adr_i(adr), .bus_ack_i(ack),
    .st_valid_i(sv), .st_ready_i(sr), .st_addr_i(sa), .st_data_i(sd),
    .redir_valid_i(rv), .redir_addr_i(ra),
    .outstanding_o(outstanding), .stall_run_o(stall_run), .ack_wait_o(ack_wait),
    .ds_stall_run_o(ds_run), .exp_addr_o(exp_addr), .last_addr_o(last_addr),
    .last_valid_o(last_valid), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle();
    cyc = 0; stb = 0; stall = 0; ack = 0; adr = '0;
    sv = 0; sr = 0; sa = '0; sd = '0; rv = 0; ra = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic bus(input logic c, input logic s, input logic st, input logic a,
                     input logic [AW-1:0] ad);
    cyc = c; stb = s; stall = st; ack = a; adr = ad;
  endtask

  task automatic strm(input logic v, input logic r, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    sv = v; sr = r; sa = a; sd = d;
  endtask

  // R10: reset state checked while reset is held, then release
  task automatic do_reset();
    idle();
    rst_n = 0;
    tick();
    tick();
    chk("R10 reset err", 32'(err), 32'h0);
    chk("R10 reset outstanding", 32'(outstanding), 32'h0);
    chk("R10 reset exp_addr", 32'(exp_addr), 32'h0);
    chk("R10 reset last_valid", 32'(last_valid), 32'h0);
    rst_n = 1;
    tick();
    tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    do_reset();

    // Vector walk: R1 R2 R3 counting, redirect and tracking with clean traffic
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      rv = v[36]; ra = v[35:28];
      cyc = v[27]; stb = v[26]; stall = v[25]; ack = v[24]; adr = v[23:16];
      tick();
      chk($sformatf("R1 vec%0d outstanding", i), 32'(outstanding), 32'(v[15:14]));
      chk($sformatf("R2 vec%0d stall_run", i), 32'(stall_run), 32'(v[13:11]));
      chk($sformatf("R2 vec%0d ack_wait", i), 32'(ack_wait), 32'(v[10:8]));
      chk($sformatf("R3 vec%0d exp_addr", i), 32'(exp_addr), 32'(v[7:0]));
      chk($sformatf("R6 vec%0d no flags", i), 32'(err), 32'h0);
    end
    idle();

    // R4: strobe without cycle sets bit 0, and it stays (R10)
    do_reset();
    bus(0, 1, 0, 0, 8'h00); tick();
    chk("R4 stb without cyc", 32'(err), 32'h001);
    idle(); tick(); tick();
    chk("R10 bit 0 sticky", 32'(err), 32'h001);

    // R4: acknowledge with nothing in flight sets bit 1
    do_reset();
    bus(1, 0, 0, 0, 8'h00); tick();
    bus(1, 0, 0, 1, 8'h00); tick();
    chk("R4 ack with zero outstanding", 32'(err), 32'h002);

    // R5: acknowledge after a CYC-low cycle sets bit 2 only; R1 count unchanged
    do_reset();
    bus(1, 1, 0, 0, 8'h00); tick();
    bus(0, 0, 0, 0, 8'h00); tick();
    bus(0, 0, 0, 1, 8'h00); tick();
    chk("R5 ack after idle cycle", 32'(err), 32'h004);
    chk("R1 cyc low keeps count", 32'(outstanding), 32'h1);

    // R6: wrong request address sets bit 3
    do_reset();
    bus(1, 1, 0, 0, 8'h05); tick();
    chk("R6 address mismatch", 32'(err), 32'h008);

    // R7 / R2: slave stall bound
    do_reset();
    bus(1, 1, 1, 0, 8'h00); tick(); tick();
    chk("R7 stall at bound run", 32'(stall_run), 32'h2);
    chk("R7 stall at bound quiet", 32'(err), 32'h000);
    tick();
    chk("R7 stall over bound", 32'(err), 32'h010);
    bus(1, 1, 0, 0, 8'h00); tick();
    chk("R2 stall run clears", 32'(stall_run), 32'h0);

    // R7: acknowledge latency bound
    do_reset();
    bus(1, 1, 0, 0, 8'h00); tick();
    bus(1, 0, 0, 0, 8'h00); tick(); tick();
    chk("R7 ack wait at bound", 32'(err), 32'h000);
    tick();
    chk("R2 ack wait count", 32'(ack_wait), 32'h3);
    chk("R7 ack wait over bound", 32'(err), 32'h020);

    // R3: redirect wins over a same-cycle acknowledge
    do_reset();
    bus(1, 1, 0, 0, 8'h00); tick();
    bus(1, 0, 0, 1, 8'h00); rv = 1; ra = 8'h40; tick();
    chk("R3 redirect priority", 32'(exp_addr), 32'h40);
    chk("R3 no flags", 32'(err), 32'h000);
    idle();

    // R9: stalled request dropping strobe sets bit 8
    do_reset();
    bus(1, 1, 1, 0, 8'h00); tick();
    bus(1, 0, 0, 0, 8'h00); tick();
    chk("R9 bus hold broken", 32'(err), 32'h100);

    // R9: same with redirect in the stalled cycle is exempt
    do_reset();
    bus(1, 1, 1, 0, 8'h00); rv = 1; ra = 8'h00; tick();
    rv = 0; bus(1, 0, 0, 0, 8'h00); tick();
    chk("R9 bus hold redirect exempt", 32'(err), 32'h000);

    // R7: downstream stall bound
    do_reset();
    strm(1, 0, 8'h03, 8'h07); tick(); tick();
    chk("R7 ds stall at bound", 32'(err), 32'h000);
    tick();
    chk("R2 ds stall run", 32'(ds_run), 32'h3);
    chk("R7 ds stall over bound", 32'(err), 32'h040);

    // R9: waiting downstream word changing data sets bit 9
    do_reset();
    strm(1, 0, 8'h04, 8'h09); tick();
    strm(1, 0, 8'h04, 8'h0A); tick();
    chk("R9 ds hold broken", 32'(err), 32'h200);

    // R9: redirect in the waiting cycle is exempt
    do_reset();
    strm(1, 0, 8'h04, 8'h09); rv = 1; tick();
    rv = 0; strm(1, 0, 8'h04, 8'h0A); tick();
    chk("R9 ds hold redirect exempt", 32'(err), 32'h000);

    // R8: sequential delivery then a gap
    do_reset();
    strm(1, 1, 8'h04, 8'h00); tick();
    chk("R8 last addr", 32'(last_addr), 32'h04);
    chk("R8 last valid", 32'(last_valid), 32'h1);
    strm(1, 1, 8'h05, 8'h00); tick();
    chk("R8 sequential ok", 32'(err), 32'h000);
    strm(1, 1, 8'h07, 8'h00); tick();
    chk("R8 sequence gap", 32'(err), 32'h080);

    // R8: redirect forgets the last address, no flag on the new start
    do_reset();
    strm(1, 1, 8'h04, 8'h00); tick();
    strm(0, 0, 8'h00, 8'h00); rv = 1; ra = 8'h30; tick();
    rv = 0;
    chk("R8 redirect clears valid", 32'(last_valid), 32'h0);
    strm(1, 1, 8'h30, 8'h00); tick();
    chk("R8 new start no flag", 32'(err), 32'h000);
    chk("R8 new start stored", 32'(last_addr), 32'h30);
    idle(); tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule